// File: doc/BRIEF.md
# Unaligned Access Memory Bridge

This block connects a single load/store requester to a memory that transfers only whole 64-bit units and has no byte enables. A request carries a byte address, a size code, a write flag and write data. The block maps it onto one or more unit transfers. A load that spans two units is fetched as two reads and spliced. A store that covers only part of a unit is turned into a read-modify-write. A store that spans two units becomes a four-step sequence.

A two-bit policy input is sampled with each request and decides what happens to a misaligned access. The access can be refused with a fault and no memory traffic. Its low address bits can be dropped so that it lands on the aligned location. Or it can be carried out exactly through split transfers. Only one request is in flight at a time.

Top module: `ualn_bridge`

## Requirements
- R1: After reset, `reqReady` is 1 and `rspDone`, `rspFault`, `memReq` are 0, `rspRdata` is 0 and `faultAddr` is 0.
- R2: A request is accepted when `reqValid` and `reqReady` are both high. `reqReady` is then low until the single cycle in which `rspDone` is high, and it returns high on the next cycle.
- R3: The size code gives the access width: 00 = 1 byte, 01 = 2, 10 = 4, 11 = 8. A load lying inside one unit issues exactly one read, of unit index `addr >> 3`. It returns the bytes zero-extended, with the lowest address in bits 7:0 (little-endian).
- R4: A load whose bytes cross from unit n into unit n+1 reads unit n, then unit n+1. The result is the requested bytes spliced in little-endian order.
- R5: A 1-byte access is never misaligned. It takes one unit read, or a read and a write, under every policy.
- R6: A store lying inside one unit that is not an aligned 8-byte store reads unit n and then writes it back. Only the addressed bytes are replaced.
- R7: A store crossing units reads n, reads n+1, writes n, then writes n+1. Only the addressed bytes change.
- R8: An 8-byte store at an 8-aligned address issues one write and no read.
- R9: An access is misaligned when `addr mod size != 0`. With policy 00, a misaligned access finishes with `rspFault` high together with `rspDone`, performs no memory transfer and returns 0 data. `faultAddr` then holds its address until the next fault.
- R10: With policy 01, a misaligned access is carried out at `addr` with its low log2(size) bits cleared. It raises no fault.
- R11: Policy 10 and policy 11 both carry out misaligned accesses exactly as requested, using R4 and R7 where they cross units.
- R12: An aligned access behaves the same under every policy and never faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Bridge can accept a request |
| reqAddr | input | ADDR_W | Byte address |
| reqSize | input | 2 | Size code (00=1, 01=2, 10=4, 11=8 bytes) |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqWdata | input | 64 | Store data, low bytes used |
| policy | input | 2 | Misalignment policy: 00 fault, 01 truncate, 10/11 split |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | 64 | Load result, valid with rspDone |
| rspFault | output | 1 | Request was refused, valid with rspDone |
| faultAddr | output | ADDR_W | Address of the last refused request |
| memReq | output | 1 | One-cycle transfer strobe |
| memWrite | output | 1 | Transfer is a write |
| memIdx | output | ADDR_W-3 | Unit index |
| memWdata | output | 64 | Unit write data |
| memRdata | input | 64 | Unit read data |
| memRvalid | input | 1 | memRdata valid this cycle |

## Verification
A wrong straddle or alignment decision shows up at the memory port at once. The transfer count or the unit order departs from the expected sequence before the request completes. A bad shift or merge amount shows up in the load result at the done pulse. For stores, it appears as corrupted neighbour bytes in the unit written back one or two cycles before done. Sweeping every size, every byte offset within a unit, both directions and all four policy codes reaches every splice amount and every sequence shape. The latency of the memory model is varied throughout the sweep.

// File: rtl/ualn_pkg.sv
package ualn_pkg;
  localparam int UNIT_BITS  = 64;
  localparam int UNIT_BYTES = UNIT_BITS / 8;
  localparam int OFF_W      = $clog2(UNIT_BYTES);

  localparam logic [1:0] POL_FAULT = 2'b00;
  localparam logic [1:0] POL_TRUNC = 2'b01;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_RDLO, S_WTLO, S_RDHI, S_WTHI, S_WRLO, S_WRHI, S_FIN
  } bridgeState_t;

  typedef struct packed {
    logic latchReq;
    logic decide;
    logic capLo;
    logic capHi;
    logic memReq;
    logic memWrite;
    logic selHi;
    logic done;
  } ctrlStrobe_t;

  typedef struct packed {
    logic isFault;
    logic isWrite;
    logic straddle;
    logic fullWord;
  } dpStatus_t;
endpackage

// File: rtl/ualn_ctrl.sv
module ualn_ctrl
  import ualn_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRvalid,
  input  dpStatus_t   st,
  output ctrlStrobe_t sb,
  output logic        reqReady
);
  bridgeState_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    sb       = '0;
    nxt      = state;
    reqReady = (state == S_IDLE);
    case (state)
      S_IDLE: if (reqValid) begin
        sb.latchReq = 1'b1;
        nxt = S_CHECK;
      end
      S_CHECK: begin
        sb.decide = 1'b1;
        if (st.isFault)                    nxt = S_FIN;
        else if (st.isWrite && st.fullWord) nxt = S_WRLO;
        else                               nxt = S_RDLO;
      end
      S_RDLO: begin
        sb.memReq = 1'b1;
        nxt = S_WTLO;
      end
      S_WTLO: if (memRvalid) begin
        sb.capLo = 1'b1;
        if (st.straddle)     nxt = S_RDHI;
        else if (st.isWrite) nxt = S_WRLO;
        else                 nxt = S_FIN;
      end
      S_RDHI: begin
        sb.memReq = 1'b1;
        sb.selHi  = 1'b1;
        nxt = S_WTHI;
      end
      S_WTHI: if (memRvalid) begin
        sb.capHi = 1'b1;
        nxt = st.isWrite ? S_WRLO : S_FIN;
      end
      S_WRLO: begin
        sb.memReq   = 1'b1;
        sb.memWrite = 1'b1;
        nxt = st.straddle ? S_WRHI : S_FIN;
      end
      S_WRHI: begin
        sb.memReq   = 1'b1;
        sb.memWrite = 1'b1;
        sb.selHi    = 1'b1;
        nxt = S_FIN;
      end
      S_FIN: begin
        sb.done = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end
endmodule

// File: rtl/ualn_dpath.sv
module ualn_dpath
  import ualn_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          sb,
  output dpStatus_t            st,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [1:0]           reqSize,
  input  logic                 reqWrite,
  input  logic [UNIT_BITS-1:0] reqWdata,
  input  logic [1:0]           policy,
  input  logic [UNIT_BITS-1:0] memRdata,
  output logic [ADDR_W-OFF_W-1:0] memIdx,
  output logic [UNIT_BITS-1:0] memWdata,
  output logic [UNIT_BITS-1:0] rspRdata,
  output logic                 rspFault,
  output logic [ADDR_W-1:0]    faultAddr
);
  localparam int IDX_W  = ADDR_W - OFF_W;
  localparam int SHIFT_W = OFF_W + 3;

  logic [ADDR_W-1:0]    origAddrQ, faultAddrQ;
  logic [1:0]           sizeQ, policyQ;
  logic                 writeQ, faultQ;
  logic [UNIT_BITS-1:0] wdataQ, loQ, hiQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      origAddrQ  <= '0;
      sizeQ      <= '0;
      policyQ    <= '0;
      writeQ     <= 1'b0;
      wdataQ     <= '0;
      loQ        <= '0;
      hiQ        <= '0;
      faultQ     <= 1'b0;
      faultAddrQ <= '0;
    end else begin
      if (sb.latchReq) begin
        origAddrQ <= reqAddr;
        sizeQ     <= reqSize;
        policyQ   <= policy;
        writeQ    <= reqWrite;
        wdataQ    <= reqWdata;
      end
      if (sb.capLo) loQ <= memRdata;
      if (sb.capHi) hiQ <= memRdata;
      if (sb.decide) begin
        faultQ <= st.isFault;
        if (st.isFault) faultAddrQ <= origAddrQ;
      end
    end
  end

  // Size decode: byte count and the address bits that must be zero.
  logic [OFF_W:0]        byteCnt;
  logic [OFF_W-1:0]      lowMask, off;
  logic                  misal;
  logic [ADDR_W-1:0]     effAddr;
  logic [UNIT_BITS-1:0]  sizeMask;
  logic [SHIFT_W-1:0]    shamt;

  always_comb begin
    byteCnt = (OFF_W+1)'(1) << sizeQ;
    lowMask = OFF_W'(byteCnt - (OFF_W+1)'(1));
    misal   = (origAddrQ[OFF_W-1:0] & lowMask) != '0;
    if (misal && policyQ == POL_TRUNC)
      effAddr = origAddrQ & ~{{(ADDR_W-OFF_W){1'b0}}, lowMask};
    else
      effAddr = origAddrQ;
    off   = effAddr[OFF_W-1:0];
    shamt = {off, 3'b000};
    case (sizeQ)
      2'd0:    sizeMask = UNIT_BITS'(64'h0000_0000_0000_00FF);
      2'd1:    sizeMask = UNIT_BITS'(64'h0000_0000_0000_FFFF);
      2'd2:    sizeMask = UNIT_BITS'(64'h0000_0000_FFFF_FFFF);
      default: sizeMask = '1;
    endcase
    st.isFault  = misal && (policyQ == POL_FAULT);
    st.isWrite  = writeQ;
    st.straddle = ({1'b0, off} + byteCnt) > (OFF_W+1)'(UNIT_BYTES);
    st.fullWord = (sizeQ == 2'd3) && (off == '0);
  end

  // Splice for loads, insert for stores, over the pair {hi, lo}.
  logic [2*UNIT_BITS-1:0] pairVal, pairShr, insMask, insData, merged;
  logic [UNIT_BITS-1:0]   loadVal;
  logic [IDX_W-1:0]       baseIdx;

  always_comb begin
    pairVal = {hiQ, loQ};
    pairShr = pairVal >> shamt;
    loadVal = pairShr[UNIT_BITS-1:0] & sizeMask;
    insMask = {{UNIT_BITS{1'b0}}, sizeMask} << shamt;
    insData = {{UNIT_BITS{1'b0}}, wdataQ & sizeMask} << shamt;
    merged  = (pairVal & ~insMask) | insData;
    baseIdx = effAddr[ADDR_W-1:OFF_W];
    memIdx  = baseIdx + IDX_W'(sb.selHi);
    memWdata = sb.selHi ? merged[2*UNIT_BITS-1:UNIT_BITS] : merged[UNIT_BITS-1:0];
    rspRdata = (sb.done && !writeQ && !faultQ) ? loadVal : '0;
    rspFault = sb.done && faultQ;
    faultAddr = faultAddrQ;
  end
endmodule

// File: rtl/ualn_bridge.sv
module ualn_bridge
  import ualn_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [1:0]              reqSize,
  input  logic                    reqWrite,
  input  logic [UNIT_BITS-1:0]    reqWdata,
  input  logic [1:0]              policy,
  output logic                    rspDone,
  output logic [UNIT_BITS-1:0]    rspRdata,
  output logic                    rspFault,
  output logic [ADDR_W-1:0]       faultAddr,
  output logic                    memReq,
  output logic                    memWrite,
  output logic [ADDR_W-OFF_W-1:0] memIdx,
  output logic [UNIT_BITS-1:0]    memWdata,
  input  logic [UNIT_BITS-1:0]    memRdata,
  input  logic                    memRvalid
);
  ctrlStrobe_t sb;
  dpStatus_t   st;

  ualn_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRvalid(memRvalid),
    .st(st), .sb(sb), .reqReady(reqReady)
  );

  ualn_dpath #(.ADDR_W(ADDR_W)) dpath_i (
    .clk(clk), .rstN(rstN), .sb(sb), .st(st),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .policy(policy), .memRdata(memRdata),
    .memIdx(memIdx), .memWdata(memWdata), .rspRdata(rspRdata),
    .rspFault(rspFault), .faultAddr(faultAddr)
  );

  assign rspDone  = sb.done;
  assign memReq   = sb.memReq;
  assign memWrite = sb.memWrite;
endmodule

// File: rtl/ualn_bridge_chk.sv
module ualn_bridge_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic rspDone,
  input logic rspFault,
  input logic memReq,
  input logic memWrite
);
  // R2
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone && reqReady);
  // R2
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> !reqReady);
  // R9
  fault_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> rspDone && !memReq);
  // R1
  idle_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !reqReady);
  // R3
  read_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWrite |=> !memReq);
endmodule

bind ualn_bridge ualn_bridge_chk chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspDone(rspDone), .rspFault(rspFault), .memReq(memReq), .memWrite(memWrite)
);

// File: tb/ualn_bridge_tb_top.sv
module ualn_bridge_tb_top;
  localparam int ADDR_W = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic [63:0] reqWdata = '0;
  logic [1:0]  policy = '0;
  logic        rspDone, rspFault, memReq, memWrite;
  logic [63:0] rspRdata, memWdata;
  logic [15:0] faultAddr;
  logic [12:0] memIdx;
  logic [63:0] memRdata = '0;
  logic        memRvalid = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [63:0] memU [16];
  logic [7:0]  refB [128];
  logic [4:0]  opLog [8];
  int          opCnt = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  ualn_bridge #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .policy(policy), .rspDone(rspDone),
    .rspRdata(rspRdata), .rspFault(rspFault), .faultAddr(faultAddr),
    .memReq(memReq), .memWrite(memWrite), .memIdx(memIdx),
    .memWdata(memWdata), .memRdata(memRdata), .memRvalid(memRvalid)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Memory model: one-cycle strobes, read data returned 1..3 cycles later.
  initial begin
    bit   pend = 0;
    int   cnt = 0;
    int   lat = 0;
    logic [3:0] pidx = '0;
    forever begin
      @(negedge clk);
      memRvalid = 1'b0;
      if (pend) begin
        if (cnt == 1) begin
          memRvalid = 1'b1;
          memRdata  = memU[pidx];
          pend = 0;
        end else cnt--;
      end
      if (memReq) begin
        if (opCnt < 8) opLog[opCnt] = {memWrite, memIdx[3:0]};
        opCnt++;
        if (memWrite) memU[memIdx[3:0]] = memWdata;
        else begin
          pend = 1;
          pidx = memIdx[3:0];
          cnt  = 1 + (lat % 3);
          lat++;
        end
      end
    end
  end

  logic [15:0] lastFault = '0;

  task automatic runReq(input int pol, input int sz, input int off,
                        input bit wr, input logic [63:0] wd);
    int addr = 32 + off;
    int n = 1 << sz;
    bit mis = (addr % n) != 0;
    bit expFault = mis && pol == 0;
    int a = (pol == 1 && mis) ? addr - (addr % n) : addr;
    bit strad = ((a % 8) + n) > 8;
    int u = a / 8;
    logic [4:0] expOps [4];
    int expCnt = 0;
    logic [63:0] expData = '0;
    string tag;
    int cyc = 0;
    bit readyBad = 0;
    logic [63:0] gotData;
    logic gotFault;
    logic [15:0] gotFA;

    if (expFault)              tag = "R9";
    else if (pol == 1 && mis)  tag = "R10";
    else if (pol == 3 && mis)  tag = "R11";
    else if (!mis && pol != 2 && sz != 0) tag = "R12";
    else if (sz == 0)          tag = "R5";
    else if (wr && n == 8 && a % 8 == 0) tag = "R8";
    else if (wr && strad)      tag = "R7";
    else if (wr)               tag = "R6";
    else if (strad)            tag = "R4";
    else                       tag = "R3";

    if (!expFault) begin
      if (wr && n == 8 && a % 8 == 0) begin
        expOps[0] = {1'b1, 4'(u)}; expCnt = 1;
      end else begin
        expOps[expCnt++] = {1'b0, 4'(u)};
        if (strad) expOps[expCnt++] = {1'b0, 4'(u + 1)};
        if (wr) begin
          expOps[expCnt++] = {1'b1, 4'(u)};
          if (strad) expOps[expCnt++] = {1'b1, 4'(u + 1)};
        end
      end
      for (int i = 0; i < n; i++) begin
        if (wr) refB[a + i] = wd[8*i +: 8];
        else    expData[8*i +: 8] = refB[a + i];
      end
    end else lastFault = 16'(addr);

    reqAddr = 16'(addr); reqSize = 2'(sz); reqWrite = wr;
    reqWdata = wd; policy = 2'(pol);
    opCnt = 0;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspDone && cyc < 200) begin
      if (reqReady) readyBad = 1;
      @(negedge clk);
      cyc++;
    end
    gotData = rspRdata; gotFault = rspFault; gotFA = faultAddr;
    chk("R2", "done arrives", 64'(rspDone), 64'd1);
    chk("R2", "ready low while busy", 64'(readyBad), 64'd0);
    chk(tag, "fault flag", 64'(gotFault), 64'(expFault));
    chk(tag, "fault address", 64'(gotFA), 64'(lastFault));
    chk(tag, "transfer count", 64'(opCnt), 64'(expCnt));
    for (int i = 0; i < expCnt && i < opCnt; i++)
      chk(tag, "transfer order", 64'(opLog[i]), 64'(expOps[i]));
    if (!wr) chk(tag, "load data", gotData, expData);
    else for (int k = 3; k <= 6; k++) begin
      logic [63:0] e;
      for (int b = 0; b < 8; b++) e[8*b +: 8] = refB[8*k + b];
      chk(tag, "memory unit", memU[k], e);
    end
    @(negedge clk);
    chk("R2", "ready after done", 64'(reqReady), 64'd1);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) refB[i] = 8'(i * 29 + 7);
    for (int k = 0; k < 16; k++)
      for (int b = 0; b < 8; b++) memU[k][8*b +: 8] = refB[8*k + b];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "reset ready", 64'(reqReady), 64'd1);
    chk("R1", "reset done", 64'(rspDone), 64'd0);
    chk("R1", "reset fault", 64'(rspFault), 64'd0);
    chk("R1", "reset memReq", 64'(memReq), 64'd0);
    chk("R1", "reset rdata", rspRdata, 64'd0);
    chk("R1", "reset faultAddr", 64'(faultAddr), 64'd0);
    begin
      int it = 0;
      for (int pol = 0; pol < 4; pol++)
        for (int wr = 0; wr < 2; wr++)
          for (int sz = 0; sz < 4; sz++)
            for (int off = 0; off < 8; off++) begin
              runReq(pol, sz, off, wr[0],
                     64'hA1B2_C3D4_E5F6_0718 ^ (64'(it) * 64'h0101_0101_0101_0101));
              it++;
            end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    fails++;
    $display("FAIL R2 watchdog actual=no completion expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule